// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that copies data between two memory spaces, host and device, by following a list of transfer records held in host memory. Each record is four 32-bit words that describe one contiguous segment: a host address, a device address, a byte count and a link to the next record. Software writes the address of the first record into the channel's list pointer and sets the transfer mode. It then starts the channel with one write to the control/status register. The channel reads each record, copies its segment one word at a time, and follows the link. It stops after the record whose link carries the end-of-list flag, sets a sticky completion bit and can raise an interrupt.

Software can stop a running channel in two ways. An abort write stops it at once. A switch-off write, which carries the off bit with the enable bit clear, also stops it. Neither sets the completion bit. A single-segment mode copies the segment held in the channel's own address and count registers and does not fetch any records. The memory side is a plain request/ready master that carries one word per handshake.

Top module: `dmac_chain`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `m_valid_o` is low. Register word offsets are: 0x00 host address, 0x04 device address, 0x08 byte count, 0x0C list pointer, 0x10 control/status, 0x14 mode.
- R2: A record at pointer P is read from host space (`m_space_o`=0) as four words in this order: {P[31:4],4'h0}+0 host address, +4 device address, +8 byte count, +12 next pointer.
- R3: Mode bit 2 selects the copy direction. When it is 1, each word is read from host space at the host address and written to device space at the device address; when it is 0, the roles are swapped. Both addresses rise by 4 and the count falls by 4 for each word.
- R4: Bit 1 of a link pointer marks the end of the list, and the channel completes after the record that carries it. A start whose list pointer already has bit 1 set completes with no bus access.
- R5: A record whose byte count is below 4 moves no data, and its link is followed.
- R6: A control/status write with bit 0 (enable) and bit 1 (start) both set starts an idle channel. Bit 0 of the control/status register reads 1 while the channel runs.
- R7: Control/status bit 3 (done) is set when a list completes. It stays set until a write with bit 3 set clears it; a write with bit 3 clear leaves it unchanged.
- R8: `irq_o` is high exactly while the done bit and mode bit 1 are both set.
- R9: A write with control/status bit 2 (abort) stops the channel in that cycle. After an abort, bit 0 reads 0, done stays 0, `irq_o` stays low and no further bus access is made.
- R10: A control/status write with bit 0 clear and bit 4 (off) set stops the channel as an abort does.
- R11: Writes to the address, count and pointer registers are ignored while the channel runs.
- R12: With mode bit 0 (list mode) clear, a start copies the segment held in the address and count registers, fetches no record, and then sets done.
- R13: A request on the master port keeps its address, data and direction until `m_ready_i` accepts it, unless the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| irq_o | output | 1 | Completion interrupt |
| m_valid_o | output | 1 | Master request valid |
| m_write_o | output | 1 | Request is a write |
| m_space_o | output | 1 | Target space: 0 host, 1 device |
| m_addr_o | output | 32 | Word-aligned byte address |
| m_wdata_o | output | 32 | Write data |
| m_ready_i | input | 1 | Request accepted this cycle; read data valid |
| m_rdata_i | input | 32 | Read data |

## Verification
The copy path is driven with several kinds of list. A single-record list with an always-ready bus confirms the order in which the record words are fetched and the final register values. A three-record list that copies device to host, includes a short record and runs against a stalling bus separates correct link following from record skipping, and shows that requests hold under backpressure. A head pointer that is already terminated, and a single-segment start, show that completion does not depend on fetching records. Long copies cut short by abort and by switch-off, and a long copy during which software rewrites the count, show whether stop commands and busy-time register writes leave memory untouched.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // register word indices (byte offset / 4)
  localparam int IX_HOST = 0;
  localparam int IX_DEV  = 1;
  localparam int IX_CNT  = 2;
  localparam int IX_PTR  = 3;
  localparam int IX_CSR  = 4;
  localparam int IX_MODE = 5;

  // control/status bits
  localparam int CB_EN    = 0;
  localparam int CB_START = 1;
  localparam int CB_ABORT = 2;
  localparam int CB_DONE  = 3;
  localparam int CB_OFF   = 4;

  // mode bits
  localparam int MB_CHAIN = 0;
  localparam int MB_IRQ   = 1;
  localparam int MB_TODEV = 2;

  localparam int EOL_BIT = 1;

  localparam logic SPACE_HOST = 1'b0;
  localparam logic SPACE_DEV  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_LINK
  } dmac_state_e;

  function automatic word_t rec_word_addr(word_t ptr, logic [1:0] idx);
    return {ptr[WORD_W-1:4], idx, 2'b00};
  endfunction

  function automatic word_t align4(word_t a);
    return {a[WORD_W-1:2], 2'b00};
  endfunction

  function automatic logic has_words(word_t cnt);
    return |cnt[WORD_W-1:2];
  endfunction

  function automatic logic is_eol(word_t ptr);
    return ptr[EOL_BIT];
  endfunction

  function automatic word_t csr_view(logic busy, logic done);
    word_t v;
    v = '0;
    v[CB_EN]   = busy;
    v[CB_DONE] = done;
    return v;
  endfunction
endpackage

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  csr_we_i,
  input  logic  mode_we_i,
  input  word_t wdata_i,
  input  logic  busy_i,
  input  logic  fin_i,
  output logic  start_o,
  output logic  stop_o,
  output logic  clr_o,
  output logic  done_o,
  output logic  chain_o,
  output logic  irq_en_o,
  output logic  to_dev_o,
  output logic  irq_o
);
  logic [2:0] mode_q;
  logic       done_q;

  assign stop_o  = csr_we_i & (wdata_i[CB_ABORT] | (~wdata_i[CB_EN] & wdata_i[CB_OFF]));
  assign start_o = csr_we_i & wdata_i[CB_EN] & wdata_i[CB_START] & ~busy_i & ~stop_o;
  assign clr_o   = csr_we_i & wdata_i[CB_DONE];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= wdata_i[2:0];
      if (fin_i)      done_q <= 1'b1;
      else if (clr_o) done_q <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign chain_o  = mode_q[MB_CHAIN];
  assign irq_en_o = mode_q[MB_IRQ];
  assign to_dev_o = mode_q[MB_TODEV];
  assign irq_o    = done_q & mode_q[MB_IRQ];
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       chain_i,
  input  logic       to_dev_i,
  input  logic       sw_we_i,
  input  logic [1:0] sw_sel_i,
  input  word_t      sw_wdata_i,
  input  logic       m_ready_i,
  input  word_t      m_rdata_i,
  output logic       busy_o,
  output logic       fin_o,
  output logic       beat_o,
  output logic       m_valid_o,
  output logic       m_write_o,
  output logic       m_space_o,
  output word_t      m_addr_o,
  output word_t      m_wdata_o,
  output word_t      host_addr_o,
  output word_t      dev_addr_o,
  output word_t      count_o,
  output word_t      dptr_o
);
  dmac_state_e st_q;
  logic [1:0]  idx_q;
  word_t       host_q, dev_q, cnt_q, dptr_q, data_q;
  logic        chain_q, to_dev_q;
  logic        hs, more;

  assign more = has_words(cnt_q);
  assign hs   = m_valid_o & m_ready_i;

  always_comb begin
    m_valid_o = 1'b0;
    m_write_o = 1'b0;
    m_space_o = SPACE_HOST;
    m_addr_o  = '0;
    unique case (st_q)
      ST_FETCH: begin
        m_valid_o = 1'b1;
        m_addr_o  = rec_word_addr(dptr_q, idx_q);
      end
      ST_READ: begin
        m_valid_o = more;
        m_space_o = to_dev_q ? SPACE_HOST : SPACE_DEV;
        m_addr_o  = align4(to_dev_q ? host_q : dev_q);
      end
      ST_WRITE: begin
        m_valid_o = 1'b1;
        m_write_o = 1'b1;
        m_space_o = to_dev_q ? SPACE_DEV : SPACE_HOST;
        m_addr_o  = align4(to_dev_q ? dev_q : host_q);
      end
      default: ;
    endcase
    if (stop_i) m_valid_o = 1'b0;
  end

  assign fin_o = ~stop_i &
    (((st_q == ST_IDLE) & start_i & chain_i & is_eol(dptr_q)) |
     ((st_q == ST_LINK) & (~chain_q | is_eol(dptr_q))));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      host_q   <= '0;
      dev_q    <= '0;
      cnt_q    <= '0;
      dptr_q   <= '0;
      data_q   <= '0;
      chain_q  <= 1'b0;
      to_dev_q <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            chain_q  <= chain_i;
            to_dev_q <= to_dev_i;
            idx_q    <= '0;
            if (!chain_i)                st_q <= ST_READ;
            else if (!is_eol(dptr_q))    st_q <= ST_FETCH;
          end else if (sw_we_i) begin
            unique case (sw_sel_i)
              2'd0: host_q <= sw_wdata_i;
              2'd1: dev_q  <= sw_wdata_i;
              2'd2: cnt_q  <= sw_wdata_i;
              default: dptr_q <= sw_wdata_i;
            endcase
          end
        end
        ST_FETCH: begin
          if (hs) begin
            idx_q <= idx_q + 2'd1;
            unique case (idx_q)
              2'd0: host_q <= m_rdata_i;
              2'd1: dev_q  <= m_rdata_i;
              2'd2: cnt_q  <= m_rdata_i;
              default: begin
                dptr_q <= m_rdata_i;
                st_q   <= ST_READ;
              end
            endcase
          end
        end
        ST_READ: begin
          if (!more) st_q <= ST_LINK;
          else if (hs) begin
            data_q <= m_rdata_i;
            st_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (hs) begin
            host_q <= host_q + 32'd4;
            dev_q  <= dev_q + 32'd4;
            cnt_q  <= cnt_q - 32'd4;
            st_q   <= ST_READ;
          end
        end
        default: begin
          idx_q <= '0;
          st_q  <= (!chain_q || is_eol(dptr_q)) ? ST_IDLE : ST_FETCH;
        end
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign beat_o      = hs & m_write_o;
  assign m_wdata_o   = data_q;
  assign host_addr_o = host_q;
  assign dev_addr_o  = dev_q;
  assign count_o     = cnt_q;
  assign dptr_o      = dptr_q;
endmodule

// File: rtl/dmac_chain.sv
module dmac_chain
  import dmac_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           irq_o,
  output logic           m_valid_o,
  output logic           m_write_o,
  output logic           m_space_o,
  output logic [31:0]    m_addr_o,
  output logic [31:0]    m_wdata_o,
  input  logic           m_ready_i,
  input  logic [31:0]    m_rdata_i
);
  localparam int SW = RAW - 2;

  logic [SW-1:0] sel_w;
  logic csr_we_w, mode_we_w, ptr_we_w;
  logic start_w, stop_w, clr_w, done_w, fin_w, busy_w, beat_w;
  logic chain_w, irq_en_w, to_dev_w;
  word_t host_w, dev_w, cnt_w, dptr_w;

  assign sel_w     = reg_addr_i[RAW-1:2];
  assign csr_we_w  = reg_we_i & (sel_w == SW'(IX_CSR));
  assign mode_we_w = reg_we_i & (sel_w == SW'(IX_MODE));
  assign ptr_we_w  = reg_we_i & (sel_w <= SW'(IX_PTR));

  dmac_csr u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .csr_we_i(csr_we_w), .mode_we_i(mode_we_w), .wdata_i(reg_wdata_i),
    .busy_i(busy_w), .fin_i(fin_w),
    .start_o(start_w), .stop_o(stop_w), .clr_o(clr_w), .done_o(done_w),
    .chain_o(chain_w), .irq_en_o(irq_en_w), .to_dev_o(to_dev_w), .irq_o(irq_o)
  );

  dmac_engine u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_w), .stop_i(stop_w), .chain_i(chain_w), .to_dev_i(to_dev_w),
    .sw_we_i(ptr_we_w), .sw_sel_i(sel_w[1:0]), .sw_wdata_i(reg_wdata_i),
    .m_ready_i(m_ready_i), .m_rdata_i(m_rdata_i),
    .busy_o(busy_w), .fin_o(fin_w), .beat_o(beat_w),
    .m_valid_o(m_valid_o), .m_write_o(m_write_o), .m_space_o(m_space_o),
    .m_addr_o(m_addr_o), .m_wdata_o(m_wdata_o),
    .host_addr_o(host_w), .dev_addr_o(dev_w), .count_o(cnt_w), .dptr_o(dptr_w)
  );

  always_comb begin
    case (sel_w)
      SW'(IX_HOST): reg_rdata_o = host_w;
      SW'(IX_DEV):  reg_rdata_o = dev_w;
      SW'(IX_CNT):  reg_rdata_o = cnt_w;
      SW'(IX_PTR):  reg_rdata_o = dptr_w;
      SW'(IX_CSR):  reg_rdata_o = csr_view(busy_w, done_w);
      SW'(IX_MODE): reg_rdata_o = {29'd0, to_dev_w, irq_en_w, chain_w};
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic        fin,
  input logic        stop,
  input logic        clr,
  input logic        done,
  input logic        irq,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_write,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata
);
  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid && !m_ready && !stop) |=>
      (stop || (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata))));

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !busy);

  // R9
  stop_nofin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |-> !fin);

  // R7
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> done);

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done) |-> $past(clr));

  // R8
  irq_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> done);

  // R6
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid |-> busy);
endmodule

bind dmac_chain dmac_chain_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .busy(busy_w), .fin(fin_w), .stop(stop_w), .clr(clr_w), .done(done_w),
  .irq(irq_o), .m_valid(m_valid_o), .m_ready(m_ready_i), .m_write(m_write_o),
  .m_addr(m_addr_o), .m_wdata(m_wdata_o)
);

// File: tb/dmac_chain_bench.sv
`timescale 1ns/1ps
module dmac_chain_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, m_valid, m_write, m_space, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;

  logic [31:0] host_mem [0:255];
  logic [31:0] dev_mem  [0:255];
  logic        stall = 1'b0;
  logic        rdy_t = 1'b0;
  int          nbus = 0, nwr = 0, log_n = 0;
  logic [31:0] log_a [0:7];
  int          nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dmac_chain u_dmac_chain (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .m_valid_o(m_valid), .m_write_o(m_write), .m_space_o(m_space),
    .m_addr_o(m_addr), .m_wdata_o(m_wdata), .m_ready_i(m_ready), .m_rdata_i(m_rdata)
  );

  assign m_ready = stall ? rdy_t : 1'b1;
  assign m_rdata = m_space ? dev_mem[m_addr[9:2]] : host_mem[m_addr[9:2]];

  always @(negedge clk) rdy_t <= ~rdy_t;

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      nbus <= nbus + 1;
      if (log_n < 8) begin
        log_a[log_n] <= m_addr;
        log_n <= log_n + 1;
      end
      if (m_write) begin
        nwr <= nwr + 1;
        if (m_space) dev_mem[m_addr[9:2]] <= m_wdata;
        else         host_mem[m_addr[9:2]] <= m_wdata;
      end
    end
  end

  function automatic logic [31:0] hp(int i);
    return 32'h1000_0000 + i * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] dp(int i);
    return 32'hD000_0000 | i;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      rd(5'h10, v);
      if (!v[0]) break;
    end
  endtask

  task automatic put_rec(int base, logic [31:0] h, logic [31:0] d, logic [31:0] c, logic [31:0] nx);
    host_mem[base/4]   = h;
    host_mem[base/4+1] = d;
    host_mem[base/4+2] = c;
    host_mem[base/4+3] = nx;
  endtask

  task automatic prep();
    wr(5'h10, 32'h8);
    @(negedge clk);
    nbus = 0; nwr = 0; log_n = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 m_valid", {31'd0, m_valid}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    prep();
    put_rec(32'h300, 32'h000, 32'h040, 32'd12, 32'h2);
    wr(5'h14, 32'h7);
    wr(5'h0C, 32'h300);
    wr(5'h10, 32'h3);
    rd(5'h10, v);
    chk("R6 busy after start", {31'd0, v[0]}, 32'h1);
    wait_idle();
    for (int i = 0; i < 4; i++) chk($sformatf("R2 fetch order %0d", i), log_a[i], 32'h300 + 4 * i);
    chk("R3 first read addr", log_a[4], 32'h000);
    chk("R3 first write addr", log_a[5], 32'h040);
    for (int i = 0; i < 3; i++) chk($sformatf("R3 dev word %0d", i), dev_mem[16 + i], hp(i));
    rd(5'h00, v); chk("R3 host addr end", v, 32'h00C);
    rd(5'h04, v); chk("R3 dev addr end", v, 32'h04C);
    rd(5'h08, v); chk("R3 count end", v, 32'h0);
    rd(5'h0C, v); chk("R4 pointer end", v, 32'h2);
    rd(5'h10, v); chk("R7 done set", {31'd0, v[3]}, 32'h1);
    chk("R8 irq high", {31'd0, irq}, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, v); chk("R7 done kept on zero write", {31'd0, v[3]}, 32'h1);
    wr(5'h10, 32'h8);
    rd(5'h10, v); chk("R7 done cleared", {31'd0, v[3]}, 32'h0);
    chk("R8 irq low after clear", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    prep();
    for (int i = 0; i < 4; i++) dev_mem[100 + i] = dp(100 + i);
    for (int i = 0; i < 4; i++) host_mem[64 + i] = 32'h0;
    host_mem[80] = 32'hDEAD_BEEF;
    put_rec(32'h300, 32'h100, 32'h190, 32'd8, 32'h310);
    put_rec(32'h310, 32'h140, 32'h140, 32'd3, 32'h320);
    put_rec(32'h320, 32'h108, 32'h198, 32'd8, 32'h2);
    stall = 1'b1;
    wr(5'h14, 32'h1);
    wr(5'h0C, 32'h300);
    wr(5'h10, 32'h3);
    wait_idle();
    stall = 1'b0;
    for (int i = 0; i < 4; i++) chk($sformatf("R3 host word %0d", i), host_mem[64 + i], dp(100 + i));
    chk("R5 short record untouched", host_mem[80], 32'hDEAD_BEEF);
    chk("R5 write count", nwr, 32'd4);
    chk("R13 bus count under stall", nbus, 32'd20);
    rd(5'h10, v); chk("R7 done after list", {31'd0, v[3]}, 32'h1);
    chk("R8 irq masked", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_eol_head();
    logic [31:0] v;
    prep();
    wr(5'h14, 32'h7);
    wr(5'h0C, 32'h2);
    wr(5'h10, 32'h3);
    rd(5'h10, v);
    chk("R4 terminated head done", {31'd0, v[3]}, 32'h1);
    chk("R4 terminated head idle", {31'd0, v[0]}, 32'h0);
    repeat (4) @(negedge clk);
    chk("R4 no bus access", nbus, 32'd0);
  endtask

  task automatic t_stop(logic [31:0] cmd, string tag);
    logic [31:0] v;
    int snap;
    prep();
    for (int i = 0; i < 64; i++) dev_mem[128 + i] = 32'h0;
    put_rec(32'h340, 32'h000, 32'h200, 32'd256, 32'h2);
    stall = 1'b1;
    wr(5'h14, 32'h7);
    wr(5'h0C, 32'h340);
    wr(5'h10, 32'h3);
    repeat (20) @(negedge clk);
    wr(5'h10, cmd);
    rd(5'h10, v);
    chk($sformatf("%s stopped", tag), {31'd0, v[0]}, 32'h0);
    chk($sformatf("%s no done", tag), {31'd0, v[3]}, 32'h0);
    chk($sformatf("%s no irq", tag), {31'd0, irq}, 32'h0);
    snap = nwr;
    repeat (20) @(negedge clk);
    chk($sformatf("%s no further writes", tag), nwr, snap);
    chk($sformatf("%s last word untouched", tag), dev_mem[191], 32'h0);
    stall = 1'b0;
  endtask

  task automatic t_busy_write();
    logic [31:0] v;
    prep();
    for (int i = 0; i < 64; i++) dev_mem[128 + i] = 32'h0;
    put_rec(32'h340, 32'h000, 32'h200, 32'd256, 32'h2);
    wr(5'h14, 32'h7);
    wr(5'h0C, 32'h340);
    wr(5'h10, 32'h3);
    repeat (10) @(negedge clk);
    wr(5'h08, 32'd4);
    wr(5'h04, 32'h3F0);
    wait_idle();
    chk("R11 full copy", nwr, 32'd64);
    chk("R11 last word", dev_mem[191], hp(63));
    rd(5'h04, v); chk("R11 dev addr end", v, 32'h300);
    rd(5'h08, v); chk("R11 count end", v, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    prep();
    wr(5'h14, 32'h4);
    wr(5'h00, 32'h000);
    wr(5'h04, 32'h380);
    wr(5'h08, 32'd16);
    wr(5'h10, 32'h3);
    wait_idle();
    for (int i = 0; i < 4; i++) chk($sformatf("R12 dev word %0d", i), dev_mem[224 + i], hp(i));
    chk("R12 no record fetch", nbus, 32'd8);
    rd(5'h10, v); chk("R12 done", {31'd0, v[3]}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      host_mem[i] = hp(i);
      dev_mem[i]  = 32'h0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_eol_head();
    t_stop(32'h4, "R9 abort");
    t_stop(32'h18, "R10 off");
    t_busy_write();
    t_direct();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule